// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the 32-bit datapath of a small load/store processor that spends several short clock cycles on each instruction. One memory array serves both instruction fetch and data access, and one ALU does every piece of arithmetic: the PC increment, the branch target, the effective address and the register-to-register result. Hidden registers hold values from one step to the next. These are an instruction register, two operand latches, an ALU result latch and a memory data latch.

The datapath makes no decisions of its own. An external sequencer drives the select and enable lines on every cycle. It reads back the opcode, the function field and the ALU zero flag, and uses them to choose the next step. A word-wide preload port lets the surrounding system fill the memory before execution starts. The PC, the ALU result latch and both operand latches are brought out so that a sequencer or a bench can observe progress.

Top module: `mc_datapath`

## Requirements
- R1: While rst_n is low, the PC holds RESET_PC, and the instruction register, both operand latches and the ALU result latch hold zero.
- R2: When ir_write is high, a clock edge loads the instruction register from memory. When ir_write is low, the instruction register keeps its value. opcode always shows bits 31:26 of the instruction register and funct shows bits 5:0.
- R3: On every edge the operand latches load the register file entries named by instruction bits 25:21 (latch A) and 20:16 (latch B). No enable is involved. Register 0 always reads as zero and ignores writes.
- R4: The ALU result latch loads the ALU output on every edge. ALU port A takes the PC when alu_src_a=0 and latch A when alu_src_a=1. ALU port B takes a value chosen by alu_src_b: latch B (00), the constant 4 (01), the sign-extended bits 15:0 (10), or that value shifted left by two (11).
- R5: alu_op selects AND (000), OR (001), ADD (010), SUB (110) or signed set-less-than (111). zero is high exactly when the ALU output is zero.
- R6: The memory address is the PC when i_or_d=0 and the ALU result latch when i_or_d=1. The word index is address bits MEM_IDX_W+1:2. mem_write stores latch B at that word on the edge.
- R7: The memory data latch loads the addressed word on every edge. When reg_write is high, the register file is written at bits 15:11 of the instruction register if reg_dst=1, or at bits 20:16 if reg_dst=0. The data written is the memory data latch if mem_to_reg=1, or the ALU result latch if mem_to_reg=0.
- R8: The PC is written when pc_write is high, or when pc_write_cond and zero are both high. Otherwise it holds. The new value is chosen by pc_source: the live ALU output (00), the ALU result latch (01), or PC[31:28] joined with bits 25:0 of the instruction register and two zero bits (10).
- R9: When host_we is high, an edge writes host_wdata to memory word host_idx. This write takes precedence over mem_write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_write | input | 1 | Unconditional PC update |
| pc_write_cond | input | 1 | PC update when zero is set |
| i_or_d | input | 1 | Memory address select |
| mem_read | input | 1 | Memory read step marker |
| mem_write | input | 1 | Store latch B to memory |
| ir_write | input | 1 | Instruction register load |
| reg_dst | input | 1 | Destination field select |
| mem_to_reg | input | 1 | Write-back data select |
| reg_write | input | 1 | Register file write enable |
| alu_src_a | input | 1 | ALU port A select |
| alu_src_b | input | 2 | ALU port B select |
| alu_op | input | 3 | ALU operation |
| pc_source | input | 2 | Next PC select |
| host_we | input | 1 | Preload write enable |
| host_idx | input | MEM_IDX_W | Preload word index |
| host_wdata | input | 32 | Preload data |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| zero | output | 1 | ALU result is zero |
| pc_o | output | 32 | Current PC |
| aluout_o | output | 32 | ALU result latch |
| a_o | output | 32 | Operand latch A |
| b_o | output | 32 | Operand latch B |

## Verification
The bench builds the block with MEM_WORDS=256 and RESET_PC=0. With these values the lower half of memory holds instructions and a 64-word window in the upper half holds data. Every branch target and jump target stays inside the program half, so no run can fetch a data word. The small memory also keeps sign-extended backward branch offsets and negative data values within reach of short random programs.

// File: rtl/mc_pkg.sv
package mc_pkg;
   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_op_e;

   localparam logic [1:0] SRCB_REG    = 2'b00;
   localparam logic [1:0] SRCB_FOUR   = 2'b01;
   localparam logic [1:0] SRCB_IMM    = 2'b10;
   localparam logic [1:0] SRCB_IMM_SH = 2'b11;

   localparam logic [1:0] PCS_ALU  = 2'b00;
   localparam logic [1:0] PCS_HOLD = 2'b01;
   localparam logic [1:0] PCS_JUMP = 2'b10;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
   import mc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [2:0]   op,
   output logic [W-1:0] y,
   output logic         zero
);
   generate
      if (W < 2) begin : g_bad_width
         $error("mc_alu: W must be at least 2");
      end
   endgenerate

   always_comb begin
      case (alu_op_e'(op))
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);

   // R5: subtracting equal operands must raise the zero flag
   always_comb begin
      if (op == ALU_SUB && a == b) begin
         p_sub_equal_zero_r5: assert (zero)
            else $error("subtract of equal operands did not set zero");
      end
   end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int W     = 32,
   parameter int NREGS = 32,
   localparam int AW   = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr_a,
   input  logic [AW-1:0] raddr_b,
   output logic [W-1:0]  rdata_a,
   output logic [W-1:0]  rdata_b
);
   generate
      if ((1 << AW) != NREGS) begin : g_bad_count
         $error("mc_regfile: NREGS must be a power of two");
      end
   endgenerate

   logic [W-1:0] regs [NREGS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      end else if (we && waddr != '0) begin
         regs[waddr] <= wdata;
      end
   end

   assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
   assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/mc_memory.sv
module mc_memory #(
   parameter int W     = 32,
   parameter int WORDS = 256,
   localparam int IW   = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] idx,
   output logic [W-1:0]  rdata,
   input  logic          we,
   input  logic [W-1:0]  wdata,
   input  logic          host_we,
   input  logic [IW-1:0] host_idx,
   input  logic [W-1:0]  host_wdata
);
   generate
      if ((1 << IW) != WORDS || WORDS < 2) begin : g_bad_depth
         $error("mc_memory: WORDS must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (host_we)  mem[host_idx] <= host_wdata;
      else if (we)  mem[idx]      <= wdata;
   end

   assign rdata = mem[idx];

   p_store_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !host_we) |=> (mem[$past(idx)] == $past(wdata)));

   p_host_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      host_we |=> (mem[$past(host_idx)] == $past(host_wdata)));
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
   import mc_pkg::*;
#(
   parameter int          MEM_WORDS = 256,
   parameter logic [31:0] RESET_PC  = 32'h0000_0000,
   localparam int         MEM_IDX_W = $clog2(MEM_WORDS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pc_write,
   input  logic                 pc_write_cond,
   input  logic                 i_or_d,
   input  logic                 mem_read,
   input  logic                 mem_write,
   input  logic                 ir_write,
   input  logic                 reg_dst,
   input  logic                 mem_to_reg,
   input  logic                 reg_write,
   input  logic                 alu_src_a,
   input  logic [1:0]           alu_src_b,
   input  logic [2:0]           alu_op,
   input  logic [1:0]           pc_source,
   input  logic                 host_we,
   input  logic [MEM_IDX_W-1:0] host_idx,
   input  logic [31:0]          host_wdata,
   output logic [5:0]           opcode,
   output logic [5:0]           funct,
   output logic                 zero,
   output logic [31:0]          pc_o,
   output logic [31:0]          aluout_o,
   output logic [31:0]          a_o,
   output logic [31:0]          b_o
);
   localparam int XLEN  = 32;
   localparam int NREGS = 32;
   localparam int RAW   = $clog2(NREGS);

   generate
      if (MEM_IDX_W + 2 > XLEN) begin : g_bad_mem
         $error("mc_datapath: memory larger than the address space");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset_pc
         $error("mc_datapath: RESET_PC must be word aligned");
      end
   endgenerate

   logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, aluout_q, mdr_q;
   logic [XLEN-1:0] sext_imm, alu_a, alu_b, alu_y, pc_next, mem_addr, mem_rdata;
   logic [XLEN-1:0] rf_a, rf_b, rf_wdata;
   logic [RAW-1:0]  rf_waddr;
   logic            pc_en;
   logic            unused_addr_bits;

   assign sext_imm = {{16{ir_q[15]}}, ir_q[15:0]};
   assign alu_a    = alu_src_a ? a_q : pc_q;

   always_comb begin
      case (alu_src_b)
         SRCB_REG:  alu_b = b_q;
         SRCB_FOUR: alu_b = 32'd4;
         SRCB_IMM:  alu_b = sext_imm;
         default:   alu_b = {sext_imm[XLEN-3:0], 2'b00};
      endcase
   end

   mc_alu #(.W(XLEN)) u_alu (
      .a(alu_a), .b(alu_b), .op(alu_op), .y(alu_y), .zero(zero)
   );

   assign mem_addr         = i_or_d ? aluout_q : pc_q;
   assign unused_addr_bits = ^{mem_addr[XLEN-1:MEM_IDX_W+2], mem_addr[1:0]};

   mc_memory #(.W(XLEN), .WORDS(MEM_WORDS)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .idx(mem_addr[MEM_IDX_W+1:2]), .rdata(mem_rdata),
      .we(mem_write), .wdata(b_q),
      .host_we(host_we), .host_idx(host_idx), .host_wdata(host_wdata)
   );

   assign rf_waddr = reg_dst ? ir_q[15:11] : ir_q[20:16];
   assign rf_wdata = mem_to_reg ? mdr_q : aluout_q;

   mc_regfile #(.W(XLEN), .NREGS(NREGS)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .we(reg_write), .waddr(rf_waddr), .wdata(rf_wdata),
      .raddr_a(ir_q[25:21]), .raddr_b(ir_q[20:16]),
      .rdata_a(rf_a), .rdata_b(rf_b)
   );

   always_comb begin
      case (pc_source)
         PCS_ALU:  pc_next = alu_y;
         PCS_HOLD: pc_next = aluout_q;
         PCS_JUMP: pc_next = {pc_q[31:28], ir_q[25:0], 2'b00};
         default:  pc_next = pc_q;
      endcase
   end

   assign pc_en = pc_write | (pc_write_cond & zero);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q     <= RESET_PC;
         ir_q     <= '0;
         a_q      <= '0;
         b_q      <= '0;
         aluout_q <= '0;
         mdr_q    <= '0;
      end else begin
         if (pc_en)    pc_q <= pc_next;
         if (ir_write) ir_q <= mem_rdata;
         a_q      <= rf_a;
         b_q      <= rf_b;
         aluout_q <= alu_y;
         mdr_q    <= mem_rdata;
      end
   end

   assign opcode   = ir_q[31:26];
   assign funct    = ir_q[5:0];
   assign pc_o     = pc_q;
   assign aluout_o = aluout_q;
   assign a_o      = a_q;
   assign b_o      = b_q;

   p_ir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ir_write |=> $stable(ir_q));

   p_r0_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ir_q[25:21]) == 5'd0) |-> (a_q == '0));

   p_aligned_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_read || mem_write) |-> (mem_addr[1:0] == 2'b00));

   p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_write && !pc_write_cond) |=> $stable(pc_q));

   p_pc_cond_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_write && pc_write_cond && !zero) |=> $stable(pc_q));

   p_jump_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_write && pc_source == PCS_JUMP) |=>
         (pc_q[1:0] == 2'b00 && pc_q[31:28] == $past(pc_q[31:28])));
endmodule

// File: tb/mc_datapath_test.sv
`timescale 1ns/1ps
module mc_datapath_test;
   localparam int MEM_WORDS = 256;
   localparam int IW        = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pc_write, pc_write_cond, i_or_d, mem_read, mem_write, ir_write;
   logic reg_dst, mem_to_reg, reg_write, alu_src_a;
   logic [1:0] alu_src_b, pc_source;
   logic [2:0] alu_op;
   logic host_we;
   logic [IW-1:0] host_idx;
   logic [31:0] host_wdata;
   logic [5:0] opcode, funct;
   logic zero;
   logic [31:0] pc_o, aluout_o, a_o, b_o;

   always #2 clk = ~clk;

   mc_datapath #(.MEM_WORDS(MEM_WORDS), .RESET_PC(32'h0)) uut (
      .clk(clk), .rst_n(rst_n), .pc_write(pc_write), .pc_write_cond(pc_write_cond),
      .i_or_d(i_or_d), .mem_read(mem_read), .mem_write(mem_write), .ir_write(ir_write),
      .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .reg_write(reg_write),
      .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
      .pc_source(pc_source), .host_we(host_we), .host_idx(host_idx),
      .host_wdata(host_wdata), .opcode(opcode), .funct(funct), .zero(zero),
      .pc_o(pc_o), .aluout_o(aluout_o), .a_o(a_o), .b_o(b_o)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [31:0] mregs [32];
   logic [31:0] mmem  [MEM_WORDS];
   logic [31:0] pc_m;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ctl_idle();
      pc_write = 0; pc_write_cond = 0; i_or_d = 0; mem_read = 0; mem_write = 0;
      ir_write = 0; reg_dst = 0; mem_to_reg = 0; reg_write = 0; alu_src_a = 0;
      alu_src_b = 2'b00; alu_op = 3'b010; pc_source = 2'b00;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic host_write(input logic [IW-1:0] idx, input logic [31:0] d);
      host_we = 1; host_idx = idx; host_wdata = d;
      step();
      host_we = 0;
      mmem[idx] = d;
   endtask

   function automatic logic [31:0] rtype(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
      return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] itype(input logic [5:0] op, input int rs,
                                          input int rt, input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   function automatic logic [2:0] fn_to_op(input logic [5:0] fn);
      case (fn)
         6'h20: return 3'b010;
         6'h22: return 3'b110;
         6'h24: return 3'b000;
         6'h25: return 3'b001;
         default: return 3'b111;
      endcase
   endfunction

   function automatic logic [31:0] alu_model(input logic [5:0] fn,
                                              input logic [31:0] x, input logic [31:0] y);
      case (fn)
         6'h20: return x + y;
         6'h22: return x - y;
         6'h24: return x & y;
         6'h25: return x | y;
         default: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      endcase
   endfunction

   task automatic run_instr(input logic [31:0] ins);
      int rs, rt, rd;
      logic [31:0] simm, exp, ea;
      rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
      simm = {{16{ins[15]}}, ins[15:0]};
      host_write(pc_m[IW+1:2], ins);
      // fetch
      ctl_idle();
      mem_read = 1; ir_write = 1; alu_src_b = 2'b01; pc_write = 1;
      step();
      chk(pc_o == pc_m + 4, "R8 pc increment", pc_o, pc_m + 4);
      chk(opcode == ins[31:26], "R2 opcode", 32'(opcode), 32'(ins[31:26]));
      chk(funct == ins[5:0], "R2 funct", 32'(funct), 32'(ins[5:0]));
      pc_m = pc_m + 4;
      // decode
      ctl_idle();
      alu_src_b = 2'b11;
      step();
      chk(a_o == mregs[rs], "R3 latch A", a_o, mregs[rs]);
      chk(b_o == mregs[rt], "R3 latch B", b_o, mregs[rt]);
      chk(aluout_o == pc_m + (simm << 2), "R4 branch target", aluout_o, pc_m + (simm << 2));
      ctl_idle();
      case (ins[31:26])
         6'h00: begin
            exp = alu_model(ins[5:0], mregs[rs], mregs[rt]);
            alu_src_a = 1; alu_src_b = 2'b00; alu_op = fn_to_op(ins[5:0]);
            #1;
            chk(zero == (exp == 0), "R5 zero flag", 32'(zero), 32'(exp == 0));
            step();
            chk(aluout_o == exp, "R5 alu result", aluout_o, exp);
            ctl_idle();
            reg_dst = 1; reg_write = 1;
            step();
            if (rd != 0) mregs[rd] = exp;
         end
         6'h23, 6'h2B: begin
            ea = mregs[rs] + simm;
            alu_src_a = 1; alu_src_b = 2'b10;
            step();
            chk(aluout_o == ea, "R4 address calc", aluout_o, ea);
            ctl_idle();
            i_or_d = 1;
            if (ins[31:26] == 6'h23) begin
               mem_read = 1;
               step();
               ctl_idle();
               mem_to_reg = 1; reg_write = 1;
               step();
               if (rt != 0) mregs[rt] = mmem[ea[IW+1:2]];
            end else begin
               mem_write = 1;
               step();
               mmem[ea[IW+1:2]] = mregs[rt];
            end
         end
         6'h04: begin
            alu_src_a = 1; alu_op = 3'b110; pc_write_cond = 1; pc_source = 2'b01;
            #1;
            chk(zero == (mregs[rs] == mregs[rt]), "R5 compare zero", 32'(zero),
                32'(mregs[rs] == mregs[rt]));
            exp = pc_m + (simm << 2);
            step();
            if (mregs[rs] == mregs[rt]) pc_m = exp;
            chk(pc_o == pc_m, "R8 branch pc", pc_o, pc_m);
         end
         default: begin
            pc_write = 1; pc_source = 2'b10;
            step();
            pc_m = {pc_m[31:28], ins[25:0], 2'b00};
            chk(pc_o == pc_m, "R8 jump pc", pc_o, pc_m);
         end
      endcase
      ctl_idle();
      step();
      chk(a_o == mregs[rs], "R7 written back A", a_o, mregs[rs]);
      chk(b_o == mregs[rt], "R7 written back B", b_o, mregs[rt]);
   endtask

   function automatic logic [5:0] rand_fn();
      case ($urandom % 5)
         0: return 6'h20;
         1: return 6'h22;
         2: return 6'h24;
         3: return 6'h25;
         default: return 6'h2A;
      endcase
   endfunction

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired, run did not complete");
         summary();
         $finish;
      end
   end

   initial begin
      int seed_v;
      int kind;
      logic [31:0] ins;
      seed_v = $urandom(32'd4242);
      for (int i = 0; i < 32; i++) mregs[i] = 0;
      host_we = 0; host_idx = 0; host_wdata = 0;
      ctl_idle();
      rst_n = 0;
      step(); step();
      chk(pc_o == 0, "R1 reset pc", pc_o, 0);
      chk(aluout_o == 0 && a_o == 0 && b_o == 0, "R1 reset latches",
          aluout_o | a_o | b_o, 0);
      chk(opcode == 0 && funct == 0, "R1 reset ir", 32'({opcode, funct}), 0);
      rst_n = 1;
      pc_m = 0;
      // preload data window through the host port (R9)
      for (int k = 128; k < 192; k++) host_write(IW'(k), $urandom);
      host_write(8'd128, 32'hFFFF_FFF0);
      host_write(8'd129, 32'd5);
      // directed corners
      run_instr(itype(6'h23, 0, 1, 16'h0200));         // R9 load of preloaded word
      chk(mregs[1] == 32'hFFFF_FFF0, "R9 preload read", mregs[1], 32'hFFFF_FFF0);
      run_instr(itype(6'h23, 0, 2, 16'h0204));
      run_instr(rtype(1, 2, 3, 6'h2A));                // signed slt: -16 < 5
      chk(mregs[3] == 1, "R5 signed slt model", mregs[3], 1);
      run_instr(rtype(1, 2, 0, 6'h20));                // write to r0 ignored (R3)
      run_instr(rtype(0, 3, 4, 6'h20));                // reads r0 as zero
      run_instr(itype(6'h04, 1, 2, 16'h0005));         // not taken
      run_instr(itype(6'h04, 3, 3, 16'hFFFC));         // taken backward, negative offset
      run_instr(itype(6'h2B, 0, 1, 16'h0208));         // store then reload (R6)
      run_instr(itype(6'h23, 0, 5, 16'h0208));
      chk(mregs[5] == 32'hFFFF_FFF0, "R6 store reload", mregs[5], 32'hFFFF_FFF0);
      run_instr({6'h02, 26'd40});
      // constrained random program
      for (int n = 0; n < 400; n++) begin
         kind = int'($urandom % 10);
         if (pc_m >= 32'h1E0) kind = 9;
         if (kind <= 2)
            ins = itype(6'h23, 0, int'($urandom % 32), 16'(32'h200 + 4 * ($urandom % 64)));
         else if (kind <= 4)
            ins = itype(6'h2B, 0, int'($urandom % 32), 16'(32'h200 + 4 * ($urandom % 64)));
         else if (kind <= 7)
            ins = rtype(int'($urandom % 32), int'($urandom % 32), int'($urandom % 32), rand_fn());
         else if (kind == 8) begin
            logic [31:0] tgt;
            tgt = 4 * ($urandom % 120);
            ins = itype(6'h04, int'($urandom % 4), int'($urandom % 4),
                        16'((tgt - (pc_m + 4)) >> 2));
         end else
            ins = {6'h02, 26'($urandom % 120)};
         run_instr(ins);
      end
      done = 1;
      summary();
      $finish;
   end
endmodule